// File: doc/BRIEF.md
# Phase-Error Recovery Controller

This block drives a 16-bit transmit word on every byte clock towards a downstream device. That device buffers the word in a phase-compensating FIFO and reports a phase-error flag when the FIFO has slipped. The controller registers the flag before it uses it. When the flag is raised while traffic is flowing, the controller sends a re-initialization request of a fixed minimum width back to the device. From that cycle on it sends a parameterised idle word instead of payload. It resumes payload only once it sees the flag low again.

Upstream payload arrives through a valid/ready handshake into a single holding register. Ready is withheld whenever the stream is blanked. A word already taken in is kept and sent after recovery, so payload is never lost, duplicated or reordered. After reset the controller stays blanked and issues no request until it has seen the error flag low at least once.

Top module: `perr_recover_ctrl`

## Requirements
- R1: The transmit word is a 16-bit register updated on every rising clock edge. While the stream is open, a payload word accepted at an edge is driven on `tx_word` after the following edge.
- R2: `phase_err_i` passes through one register stage. If it is high at edge k while the stream is open, `reinit_req` is high after edge k+1.
- R3: Each request is high for exactly PULSE_CYC consecutive cycles (default 2, never less than 2), even if the error clears sooner.
- R4: While `reinit_req` is high, and for as long as the registered error stays high, `tx_word` carries the idle word.
- R5: If `phase_err_i` is low at edge m after a request has completed, `in_ready` is high after edge m+1, and payload can appear on `tx_word` after edge m+2.
- R6: A continuously high error produces exactly one request. A new request needs the registered error to be seen low (stream reopened) and then high again.
- R7: `in_ready` is low whenever the stream is blanked, and in particular while `reinit_req` is high. Every accepted word is transmitted exactly once, in acceptance order.
- R8: Synchronous active-high reset sets `reinit_req` low, `tx_word` to the idle word and `in_ready` low. The block stays blanked, and issues no request, until the first edge at which the registered error is low.
- R9: The idle word is the parameter IDLE_WORD (default 16'h0000). It is also sent when the stream is open but no payload word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_err_i | input | 1 | Phase-error flag from the downstream FIFO |
| in_data | input | 16 | Payload word from upstream |
| in_valid | input | 1 | Payload word present |
| in_ready | output | 1 | Payload word taken at this edge when valid |
| tx_word | output | 16 | Transmit word towards the downstream FIFO |
| reinit_req | output | 1 | FIFO re-initialization request |

## Verification
An error level driven at one edge shows up in the request two edges later, and a cleared error reopens `in_ready` two edges later. A payload word taken at an edge reaches `tx_word` one edge after that. The bench drives inputs just after each rising edge and compares every output at the following falling edge against a behavioural model that steps on the same rising edge. The request and resume latencies are also measured directly, by counting falling edges from the stimulus, against the expected count of three. Request pulse widths, the number of requests per error episode and the payload ordering are tallied on the way.

// File: rtl/perr_pkg.sv
package perr_pkg;

  // Phases of the recovery handshake
  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,   // after reset, waiting for a clear error flag
    PH_RUN   = 2'd1,   // payload flowing
    PH_PULSE = 2'd2,   // re-init request being driven
    PH_WAIT  = 2'd3    // request done, waiting for error to clear
  } rec_phase_t;

endpackage

// File: rtl/perr_sync.sv
module perr_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic err_in,
  output logic err_out
);

  logic [STAGES-1:0] chain_q;

  // Reset to "error present" so nothing is sent until a clear flag arrives
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= err_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b1;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign err_out = chain_q[STAGES-1];

endmodule

// File: rtl/perr_seq.sv
module perr_seq
  import perr_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic err_q,
  output logic send_en,
  output logic reinit_req
);

  localparam int PW  = (PULSE_CYC < 2) ? 2 : PULSE_CYC;
  localparam int CW  = $clog2(PW + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PW - 1);

  rec_phase_t       phase_q, phase_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             req_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    req_d   = reinit_req;
    unique case (phase_q)
      PH_BOOT: begin
        if (!err_q) phase_d = PH_RUN;
      end
      PH_RUN: begin
        if (err_q) begin
          phase_d = PH_PULSE;
          cnt_d   = CNT_LOAD;
          req_d   = 1'b1;
        end
      end
      PH_PULSE: begin
        if (cnt_q == '0) begin
          req_d   = 1'b0;
          phase_d = err_q ? PH_WAIT : PH_RUN;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WAIT: begin
        if (!err_q) phase_d = PH_RUN;
      end
      default: phase_d = PH_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_BOOT;
      cnt_q      <= '0;
      reinit_req <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cnt_q      <= cnt_d;
      reinit_req <= req_d;
    end
  end

  // Payload may move only in the running phase with a clear flag
  assign send_en = (phase_q == PH_RUN) && !err_q;

endmodule

// File: rtl/perr_txpath.sv
module perr_txpath #(
  parameter int          DATA_W    = 16,
  parameter logic [15:0] IDLE_WORD = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] tx_word
);

  localparam logic [DATA_W-1:0] IDLE_V = DATA_W'(IDLE_WORD);

  logic [DATA_W-1:0] hold_data_q;
  logic              hold_full_q;
  logic              take;

  assign in_ready = send_en;
  assign take     = in_valid && send_en;

  // Holding register: refilled only while the stream is open
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q <= 1'b0;
    end else if (send_en) begin
      hold_full_q <= take;
    end
  end

  always_ff @(posedge clk) begin
    if (take) hold_data_q <= in_data;
  end

  // Output register: payload when open and held, idle otherwise
  always_ff @(posedge clk) begin
    if (rst)                         tx_word <= IDLE_V;
    else if (send_en && hold_full_q) tx_word <= hold_data_q;
    else                             tx_word <= IDLE_V;
  end

endmodule

// File: rtl/perr_recover_ctrl.sv
module perr_recover_ctrl #(
  parameter int          DATA_W     = 16,
  parameter int          PULSE_CYC  = 2,
  parameter int          SYNC_STAGES = 1,
  parameter logic [15:0] IDLE_WORD  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_err_i,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] tx_word,
  output logic              reinit_req
);

  logic err_q;
  logic send_en;

  perr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .err_in  (phase_err_i),
    .err_out (err_q)
  );

  perr_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .err_q      (err_q),
    .send_en    (send_en),
    .reinit_req (reinit_req)
  );

  perr_txpath #(.DATA_W(DATA_W), .IDLE_WORD(IDLE_WORD)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .send_en  (send_en),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_word  (tx_word)
  );

endmodule

// File: rtl/perr_recover_chk.sv
module perr_recover_chk #(
  parameter int          DATA_W    = 16,
  parameter logic [15:0] IDLE_WORD = 16'h0000
) (
  input logic              clk,
  input logic              rst,
  input logic              err_q,
  input logic              in_ready,
  input logic [DATA_W-1:0] tx_word,
  input logic              reinit_req
);

  localparam logic [DATA_W-1:0] IDLE_V = DATA_W'(IDLE_WORD);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!reinit_req && tx_word == IDLE_V && !in_ready)); // R8

  AST_REQ_FROM_ERR: assert property (@(posedge clk) disable iff (rst)
    $rose(reinit_req) |-> $past(err_q)); // R2

  AST_REQ_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(reinit_req) |=> reinit_req); // R3

  AST_IDLE_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    reinit_req |-> (tx_word == IDLE_V)); // R4

  AST_NO_READY_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    reinit_req |-> !in_ready); // R7

  AST_RESUME_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> !$past(err_q)); // R5

endmodule

bind perr_recover_ctrl perr_recover_chk #(.DATA_W(DATA_W), .IDLE_WORD(IDLE_WORD)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .err_q      (err_q),
  .in_ready   (in_ready),
  .tx_word    (tx_word),
  .reinit_req (reinit_req)
);

// File: tb/perr_recover_ctrl_tb.sv
`timescale 1ns/1ps
module perr_recover_ctrl_tb;

  localparam logic [15:0] IDLE = 16'h0000;
  localparam int PW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_err_i = 1'b1;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] tx_word;
  logic        reinit_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int vmode = 0;          // 0 no valid, 1 always, 2 gapped
  int rises = 0;
  int run_len = 0;
  int accepted = 0;
  int emitted = 0;
  logic prev_req = 1'b0;
  logic [15:0] next_word = 16'h1000;
  logic [15:0] src[$];

  // behavioural reference
  int m_mode = 0;         // 0 boot, 1 run, 2 pulse, 3 wait
  int m_cnt = 0;
  bit m_errq = 1'b1;
  bit m_req = 1'b0;
  logic [15:0] m_tx = IDLE;
  logic [15:0] m_hold[$];

  always #2.5 clk = ~clk;

  perr_recover_ctrl #(.IDLE_WORD(IDLE)) u_dut (
    .clk(clk), .rst(rst), .phase_err_i(phase_err_i),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tx_word(tx_word), .reinit_req(reinit_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model steps on the same edge as the design
  always @(posedge clk) begin
    bit go;
    cyc++;
    if (rst) begin
      m_mode = 0; m_errq = 1'b1; m_req = 1'b0; m_tx = IDLE; m_cnt = 0;
      m_hold.delete();
    end else begin
      go = (m_mode == 1) && !m_errq;
      if (go) begin
        m_tx = (m_hold.size() > 0) ? m_hold.pop_front() : IDLE;
        if (in_valid) begin
          m_hold.push_back(in_data);
          void'(src.pop_front());
          accepted++;
        end
      end else begin
        m_tx = IDLE;
      end
      case (m_mode)
        0: if (!m_errq) m_mode = 1;
        1: if (m_errq) begin m_mode = 2; m_cnt = PW - 1; m_req = 1'b1; end
        2: if (m_cnt == 0) begin m_req = 1'b0; m_mode = m_errq ? 3 : 1; end
           else m_cnt--;
        default: if (!m_errq) m_mode = 1;
      endcase
      m_errq = phase_err_i;
    end
  end

  // upstream source, driven just after the edge
  always @(posedge clk) begin
    #1;
    while (src.size() < 4) begin src.push_back(next_word); next_word++; end
    in_data  = src[0];
    in_valid = (vmode == 1) || (vmode == 2 && (cyc % 3 != 1));
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check(tx_word == m_tx, "R1/R4 tx_word", tx_word, m_tx);
      check(reinit_req == m_req, "R2/R3 reinit_req", reinit_req, m_req);
      check(in_ready == ((m_mode == 1) && !m_errq), "R7 in_ready", in_ready,
            (m_mode == 1) && !m_errq);
      if (tx_word != IDLE) emitted++;
      if (reinit_req && !prev_req) rises++;
      if (reinit_req) run_len++;
      else if (run_len > 0) begin
        check(run_len == PW, "R3 pulse width", run_len, PW);
        run_len = 0;
      end
    end
    prev_req = reinit_req;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic set_err(input logic v);
    @(posedge clk); #1; phase_err_i = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic negedges_until_req(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!reinit_req && k < 20);
  endtask

  task automatic negedges_until_ready(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!in_ready && k < 20);
  endtask

  initial begin
    int k;
    int r0;
    // R8: reset with the error flag high
    vmode = 1;
    wait_cyc(4);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(reinit_req == 1'b0, "R8 reset req", reinit_req, 0);
    check(tx_word == IDLE, "R8 reset tx", tx_word, IDLE);
    check(in_ready == 1'b0, "R8 reset ready", in_ready, 0);
    wait_cyc(8);
    check(rises == 0, "R8 no request from boot", rises, 0);
    check(in_ready == 1'b0, "R8 still blanked", in_ready, 0);

    // R1: streaming
    set_err(1'b0);
    wait_cyc(30);
    vmode = 0;
    wait_cyc(6);
    @(negedge clk);
    check(tx_word == IDLE, "R9 idle when empty", tx_word, IDLE);

    // R2, R5, R6: long error with gapped traffic
    vmode = 2;
    wait_cyc(10);
    r0 = rises;
    set_err(1'b1);
    negedges_until_req(k);
    check(k == 3, "R2 request latency", k, 3);
    wait_cyc(20);
    check(rises - r0 == 1, "R6 single request per episode", rises - r0, 1);
    check(in_ready == 1'b0, "R7 ready held low", in_ready, 0);
    set_err(1'b0);
    negedges_until_ready(k);
    check(k == 3, "R5 resume latency", k, 3);
    wait_cyc(15);

    // R3: one-cycle error still gives a full pulse
    r0 = rises;
    set_err(1'b1);
    set_err(1'b0);
    wait_cyc(10);
    check(rises - r0 == 1, "R3 short error one request", rises - r0, 1);

    // R6: error toggling around the pulse
    vmode = 1;
    set_err(1'b1); set_err(1'b0); set_err(1'b1); set_err(1'b0);
    set_err(1'b1); wait_cyc(3); set_err(1'b0);
    wait_cyc(20);

    // R7: ordering and count of payload
    vmode = 0;
    wait_cyc(6);
    @(negedge clk);
    check(emitted == accepted, "R7 every word sent once", emitted, accepted);

    // R8: reset mid-stream
    vmode = 1;
    wait_cyc(5);
    @(posedge clk); #1; rst = 1'b1;
    wait_cyc(3);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(tx_word == IDLE && !reinit_req, "R8 reset mid-stream", tx_word, IDLE);
    wait_cyc(20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule